// File: doc/BRIEF.md
# Load-Use Stall Unit

This block belongs to the decode stage of a five-stage in-order pipeline. Each cycle it compares the two source register fields of the instruction in decode against the destination held in the decode-to-execute pipeline register. It reports a hazard only when that older instruction is a load that writes a real register, because the loaded word reaches the memory-to-writeback register one cycle after the consumer would need it in execute. Every other producer is left to the bypass network.

On a hazard the unit asks for a one-cycle bubble. The fetch address and the fetch-to-decode register keep their values, and the control field that would go into the decode-to-execute register is forced to all zeros. The slot that follows then has no architectural effect. In the next cycle the load has moved on, so the request clears by itself. The held instruction is checked again and passes into execute. The unit is purely combinational.

Top module: `load_use_stall_unit`

## Requirements
- R1: When the execute-side instruction is a load (`ex_is_load`=1) with `ex_wr_en`=1 and a nonzero `ex_dst`, and `ex_dst` equals `dec_src_a`, `fetch_hold`=1 in the same cycle.
- R2: The same holds when `ex_dst` equals `dec_src_b` instead of `dec_src_a`.
- R3: A producer that is not a load (`ex_is_load`=0) never raises `fetch_hold`, even when its destination matches a source.
- R4: A producer with `ex_wr_en`=0 never raises `fetch_hold`.
- R5: Destination register 0 (`ex_dst`=0) never raises `fetch_hold`, whatever the other inputs are.
- R6: `fetch_hold`, `decode_hold` and `bubble_insert` are always equal to one another.
- R7: While `bubble_insert`=1, `ex_ctrl_out` is all zeros. Otherwise `ex_ctrl_out` equals `dec_ctrl_in`.
- R8: In a pipeline that advances when no hold is asked and turns a hold into a zeroed slot, each load followed directly by a use produces exactly one bubble. The held instruction enters execute in the next cycle, and the order of instructions in execute is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | AW | First source register index of the instruction in decode |
| dec_src_b | input | AW | Second source register index of the instruction in decode |
| dec_ctrl_in | input | CW | Control field decoded for the instruction in decode |
| ex_dst | input | AW | Destination register index held in the decode-to-execute register |
| ex_wr_en | input | 1 | Register write enable held in the decode-to-execute register |
| ex_is_load | input | 1 | Load flag held in the decode-to-execute register |
| fetch_hold | output | 1 | Keep the fetch address unchanged this cycle |
| decode_hold | output | 1 | Keep the fetch-to-decode register unchanged this cycle |
| bubble_insert | output | 1 | The slot written into decode-to-execute this cycle is a bubble |
| ex_ctrl_out | output | CW | Control field to load into the decode-to-execute register |

## Verification
The checker's properties are combinational relations between the ports at each moment. They assume only that the inputs hold defined values, and no ordering of inputs over time. The one-cycle length of a stall depends on the surrounding pipeline: whenever a hold is asked, that pipeline must write a zeroed slot with write enable and load flag both clear. The bench builds a small behavioural pipeline around the unit that does exactly this. It feeds the unit a directed program followed by a random one over a small set of registers, so that matches, register 0, non-writing loads and back-to-back loads all occur often.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Which decode source collided with the pending load (for observation).
  typedef enum logic [1:0] {
    HZ_NONE = 2'd0,
    HZ_SRC_A = 2'd1,
    HZ_SRC_B = 2'd2,
    HZ_BOTH = 2'd3
  } hz_src_e;

  function automatic hz_src_e classify_hits(input logic hit_a, input logic hit_b);
    return hz_src_e'({hit_b, hit_a});
  endfunction
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int AW = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] src_idx,
  input  logic [AW-1:0]           dst_idx,
  output logic [NSRC-1:0]         hit
);
  function automatic logic same_reg(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return (a ^ b) == '0;
  endfunction

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign hit[g] = same_reg(src_idx[g], dst_idx);
  end
endmodule

// File: rtl/hzd_stall_decide.sv
module hzd_stall_decide #(
  parameter int AW = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0] hit,
  input  logic [AW-1:0]   dst_idx,
  input  logic            wr_en,
  input  logic            is_load,
  output logic            load_live,
  output logic            stall
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  // A pending result can only arrive late if it comes from memory
  // and lands in a register that actually holds state.
  function automatic logic late_producer(input logic we, input logic ld,
                                         input logic [AW-1:0] rd);
    return we & ld & (rd != ZERO_REG);
  endfunction

  assign load_live = late_producer(wr_en, is_load, dst_idx);
  assign stall     = load_live & (|hit);
endmodule

// File: rtl/hzd_bubble_mux.sv
module hzd_bubble_mux #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] ctrl_in,
  input  logic          kill,
  output logic [CW-1:0] ctrl_out
);
  for (genvar b = 0; b < CW; b++) begin : g_bit
    assign ctrl_out[b] = ctrl_in[b] & ~kill;
  end
endmodule

// File: rtl/load_use_stall_unit.sv
module load_use_stall_unit #(
  parameter int AW = 5,
  parameter int CW = 8
) (
  input  logic [AW-1:0] dec_src_a,
  input  logic [AW-1:0] dec_src_b,
  input  logic [CW-1:0] dec_ctrl_in,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wr_en,
  input  logic          ex_is_load,
  output logic          fetch_hold,
  output logic          decode_hold,
  output logic          bubble_insert,
  output logic [CW-1:0] ex_ctrl_out
);
  import hzd_pkg::*;

  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] src_vec;
  logic [NSRC-1:0]         src_hit;
  logic                    load_live;
  logic                    stall_req;
  hz_src_e                 hit_kind;

  assign src_vec[0] = dec_src_a;
  assign src_vec[1] = dec_src_b;

  hzd_src_match #(.AW(AW), .NSRC(NSRC)) u_match (
    .src_idx (src_vec),
    .dst_idx (ex_dst),
    .hit     (src_hit)
  );

  hzd_stall_decide #(.AW(AW), .NSRC(NSRC)) u_decide (
    .hit       (src_hit),
    .dst_idx   (ex_dst),
    .wr_en     (ex_wr_en),
    .is_load   (ex_is_load),
    .load_live (load_live),
    .stall     (stall_req)
  );

  hzd_bubble_mux #(.CW(CW)) u_bubble (
    .ctrl_in  (dec_ctrl_in),
    .kill     (stall_req),
    .ctrl_out (ex_ctrl_out)
  );

  assign hit_kind      = load_live ? classify_hits(src_hit[0], src_hit[1]) : HZ_NONE;
  assign fetch_hold    = stall_req;
  assign decode_hold   = stall_req;
  assign bubble_insert = stall_req;
endmodule

// File: rtl/load_use_stall_unit_chk.sv
module load_use_stall_unit_chk #(
  parameter int AW = 5,
  parameter int CW = 8
) (
  input logic [AW-1:0] dec_src_a,
  input logic [AW-1:0] dec_src_b,
  input logic [CW-1:0] dec_ctrl_in,
  input logic [AW-1:0] ex_dst,
  input logic          ex_wr_en,
  input logic          ex_is_load,
  input logic          fetch_hold,
  input logic          decode_hold,
  input logic          bubble_insert,
  input logic [CW-1:0] ex_ctrl_out,
  input logic [1:0]    hit_kind
);
  always_comb begin
    // R1
    src_a_stall_chk: assert (!(ex_is_load && ex_wr_en && ex_dst != '0 &&
                               ex_dst == dec_src_a) || fetch_hold);
    // R2
    src_b_stall_chk: assert (!(ex_is_load && ex_wr_en && ex_dst != '0 &&
                               ex_dst == dec_src_b) || fetch_hold);
    // R3
    non_load_quiet_chk: assert (ex_is_load || !fetch_hold);
    // R4
    no_write_quiet_chk: assert (ex_wr_en || !fetch_hold);
    // R5
    zero_dst_quiet_chk: assert (ex_dst != '0 || !fetch_hold);
    // R6
    holds_agree_chk: assert (fetch_hold == decode_hold && decode_hold == bubble_insert);
    // R7
    bubble_zero_chk: assert (!bubble_insert || ex_ctrl_out == '0);
    // R7
    pass_through_chk: assert (bubble_insert || ex_ctrl_out == dec_ctrl_in);
    // R1
    kind_matches_hold_chk: assert ((hit_kind != 2'd0) == fetch_hold);
  end
endmodule

bind load_use_stall_unit load_use_stall_unit_chk #(.AW(AW), .CW(CW)) u_chk (
  .dec_src_a     (dec_src_a),
  .dec_src_b     (dec_src_b),
  .dec_ctrl_in   (dec_ctrl_in),
  .ex_dst        (ex_dst),
  .ex_wr_en      (ex_wr_en),
  .ex_is_load    (ex_is_load),
  .fetch_hold    (fetch_hold),
  .decode_hold   (decode_hold),
  .bubble_insert (bubble_insert),
  .ex_ctrl_out   (ex_ctrl_out),
  .hit_kind      (hit_kind)
);

// File: tb/load_use_stall_unit_tb.sv
module load_use_stall_unit_tb;
  localparam int AW = 5;
  localparam int CW = 8;
  localparam int MAXP = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] dec_src_a, dec_src_b, ex_dst;
  logic [CW-1:0] dec_ctrl_in, ex_ctrl_out;
  logic ex_wr_en, ex_is_load, fetch_hold, decode_hold, bubble_insert;

  load_use_stall_unit #(.AW(AW), .CW(CW)) u_dut (
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_ctrl_in(dec_ctrl_in),
    .ex_dst(ex_dst), .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load),
    .fetch_hold(fetch_hold), .decode_hold(decode_hold),
    .bubble_insert(bubble_insert), .ex_ctrl_out(ex_ctrl_out)
  );

  int checks = 0, failures = 0, cycles = 0, n = 0;
  bit done = 0;
  int p_a[MAXP], p_b[MAXP], p_d[MAXP], p_we[MAXP], p_ld[MAXP], p_ctl[MAXP];
  int seen[$], want[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int a, input int b, input int d, input int we, input int ld);
    p_a[n] = a; p_b[n] = b; p_d[n] = d; p_we[n] = we; p_ld[n] = ld;
    p_ctl[n] = 8'h80 | n;
    n++;
  endtask

  function automatic bit ref_stall(input int prod, input int cons);
    if (prod < 0 || p_ld[prod] == 0 || p_we[prod] == 0 || p_d[prod] == 0) return 0;
    return (p_d[prod] == p_a[cons]) || (p_d[prod] == p_b[cons]);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pc = 0;
    int ex_idx = -1;
    int ex_d = 0, ex_we = 0, ex_ld = 0, ex_ctl = 0;
    put(0, 0, 5, 1, 1);   put(5, 1, 6, 1, 0);    // R1 load then src_a use
    put(2, 0, 7, 1, 1);   put(3, 7, 8, 1, 0);    // R2 load then src_b use
    put(1, 0, 0, 1, 1);   put(0, 0, 9, 1, 0);    // R5 load to register 0
    put(1, 0, 4, 0, 1);   put(4, 4, 2, 1, 0);    // R4 non-writing load
    put(1, 2, 3, 1, 0);   put(3, 3, 1, 1, 0);    // R3 ALU producer
    put(0, 0, 6, 1, 1);   put(6, 0, 10, 1, 1);   put(10, 10, 11, 1, 0); // chain
    put(0, 0, 12, 1, 1);  put(1, 2, 13, 1, 0);   put(12, 0, 14, 1, 0);  // gap of one
    for (int i = 0; i < 40; i++)
      put($urandom_range(3), $urandom_range(3), $urandom_range(3),
          $urandom_range(1), $urandom_range(1));
    for (int i = 0; i < n; i++) begin
      if (i > 0 && ref_stall(i - 1, i)) want.push_back(-1);
      want.push_back(i);
    end

    // Reset-like idle state: all inputs zero, no hold, zero control.
    dec_src_a = '0; dec_src_b = '0; dec_ctrl_in = '0;
    ex_dst = '0; ex_wr_en = 1'b0; ex_is_load = 1'b0;
    @(negedge clk); #1;
    check(fetch_hold == 1'b0, "R3 idle", int'(fetch_hold), 0);
    check(ex_ctrl_out == '0, "R7 idle", int'(ex_ctrl_out), 0);

    while (pc < n || ex_idx >= 0) begin
      bit idv, exp;
      string tag;
      @(negedge clk);
      idv = pc < n;
      dec_src_a   = idv ? AW'(p_a[pc]) : '0;
      dec_src_b   = idv ? AW'(p_b[pc]) : '0;
      dec_ctrl_in = idv ? CW'(p_ctl[pc]) : '0;
      ex_dst = AW'(ex_d); ex_wr_en = ex_we[0]; ex_is_load = ex_ld[0];
      #2;
      exp = ex_ld == 1 && ex_we == 1 && ex_d != 0 &&
            (ex_d == int'(dec_src_a) || ex_d == int'(dec_src_b));
      if (exp) tag = (ex_d == int'(dec_src_a)) ? "R1" : "R2";
      else if (ex_ld == 0) tag = "R3";
      else if (ex_we == 0) tag = "R4";
      else if (ex_d == 0) tag = "R5";
      else tag = "R1/R2 no match";
      check(fetch_hold == exp, tag, int'(fetch_hold), int'(exp));
      check(decode_hold == fetch_hold && bubble_insert == fetch_hold, "R6",
            int'({fetch_hold, decode_hold, bubble_insert}), exp ? 7 : 0);
      check(ex_ctrl_out == (exp ? CW'(0) : dec_ctrl_in), "R7",
            int'(ex_ctrl_out), exp ? 0 : int'(dec_ctrl_in));
      // Advance the surrounding pipeline from the unit's own outputs.
      if (fetch_hold) begin
        ex_idx = -1; ex_d = 0; ex_we = 0; ex_ld = 0; ex_ctl = int'(ex_ctrl_out);
        check(ex_ctl == 0, "R8 bubble slot control", ex_ctl, 0);
        seen.push_back(-1);
      end else if (idv) begin
        ex_idx = pc; ex_d = p_d[pc]; ex_we = p_we[pc]; ex_ld = p_ld[pc];
        ex_ctl = int'(ex_ctrl_out);
        seen.push_back(pc);
        pc++;
      end else begin
        ex_idx = -1; ex_d = 0; ex_we = 0; ex_ld = 0; ex_ctl = 0;
      end
    end

    check(seen.size() == want.size(), "R8 slot count", seen.size(), want.size());
    for (int i = 0; i < want.size() && i < seen.size(); i++)
      if (seen[i] != want[i])
        check(0, "R8 execute order", seen[i], want[i]);
    check(1, "R8 sequence compared", 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule